// File: doc/BRIEF.md
# Word Rotate-and-Mask Execution Unit

This execution slice serves a 64-bit register machine. It takes a 32-bit instruction word, the two source register values and the incoming summary-overflow flag. It then produces the destination register index, a 64-bit result and, when asked for, a 4-bit condition-field update. The low word of the first source is rotated left, by either an immediate amount or the low bits of the second source. The rotated word is ANDed with a contiguous mask whose bounds are immediate begin and end indices. The mask wraps around when the begin index is past the end index.

The unit sits behind a single valid/ready register stage. An accepted operation shows up at the outputs one cycle later. A new operation can enter every cycle as long as the consumer is taking results. Opcodes that this unit does not execute come out as flagged illegal, with no write of any kind.

Top module: `rotmask_unit`

## Requirements
- R1: Instruction fields use bit 0 as the most significant bit: opcode in bits 0–5, first-source index in 6–10, destination index in 11–15, immediate amount or second-source index in 16–20, mask begin in 21–25, mask end in 26–30, and the record flag in bit 31. `rd_idx_o` carries the destination field.
- R2: With opcode 23, the rotate amount is `rb_val_i[4:0]`. The upper bits of `rb_val_i` and the immediate amount field have no effect on the result.
- R3: With opcode 21, the rotate amount is the 5-bit immediate field (bits 16–20). `rb_val_i` has no effect on the result.
- R4: Only `rs_val_i[31:0]` is used, and it is rotated left, so bits leaving the top come back in at the bottom. The upper half of `rs_val_i` has no effect.
- R5: The mask uses the numbering where bit 0 is the most significant bit. It sets bits begin through end inclusive. When begin > end, it sets bits begin..31 together with 0..end. When begin = end+1 (mod 32) every bit is set, and when begin = end exactly one bit is set.
- R6: `result_o[63:32]` is always zero, and `result_o[31:0]` is the rotated word ANDed with the mask.
- R7: With the record flag set, `cr_we_o` is 1 and `cr0_o` = {LT, GT, EQ, SO}, with LT in bit 3. LT, GT and EQ come from a signed comparison of the 32-bit result with zero, and SO is a copy of `so_i`. With the record flag clear, `cr_we_o` is 0.
- R8: `xer_we_o` is never asserted.
- R9: Any opcode other than 21 or 23 yields `illegal_o`=1, `rd_we_o`=0, `cr_we_o`=0 and a zero result, all held for that output beat.
- R10: An input accepted on a rising edge (`in_valid_i` and `in_ready_o` both high) appears with `out_valid_o` after that edge. `in_ready_o` is high when the stage is empty or `out_ready_i` is high. While the output is stalled, the output holds its value and new inputs are not taken.
- R11: After reset, `out_valid_o`, `rd_we_o`, `cr_we_o` and `illegal_o` are 0, and `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation offered |
| in_ready_o | output | 1 | Stage can take an operation |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 64 | First source value |
| rb_val_i | input | 64 | Second source value |
| so_i | input | 1 | Incoming summary-overflow flag |
| out_valid_o | output | 1 | Result beat present |
| out_ready_i | input | 1 | Consumer takes the beat |
| rd_idx_o | output | 5 | Destination register index |
| rd_we_o | output | 1 | Destination write enable |
| result_o | output | 64 | Zero-extended result |
| cr_we_o | output | 1 | Condition field 0 write enable |
| cr0_o | output | 4 | {LT, GT, EQ, SO} |
| illegal_o | output | 1 | Unsupported opcode on this beat |
| xer_we_o | output | 1 | Exception-register write, always 0 |

## Verification
The wrap-around mask bounds and the two degenerate cases (all ones and a single bit) appear only for particular begin/end pairs. The stimulus therefore sweeps all 1024 pairs, and the rotate amount and record flag vary along with the pair. The two sources of the rotate amount are exercised with decoys: the field that should be ignored always holds a different value from the one in use. A stall with a second operation waiting shows that the held beat survives and that the waiting operation is taken only after the consumer frees the stage.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned OPC_W  = 6;
  localparam int unsigned IDX_W  = 5;

  // bit 0 of the instruction is its MSB, so packing order follows field order
  typedef struct packed {
    logic [OPC_W-1:0] opc;
    logic [IDX_W-1:0] src_a;
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] amt_or_b;
    logic [IDX_W-1:0] m_begin;
    logic [IDX_W-1:0] m_end;
    logic             rec;
  } insn_t;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cr_t;
endpackage

// File: rtl/rotmask_decode.sv
module rotmask_decode
  import rotmask_pkg::*;
#(
  parameter logic [OPC_W-1:0] OPC_IMM = 6'd21,
  parameter logic [OPC_W-1:0] OPC_REG = 6'd23
) (
  input  logic [INSN_W-1:0] instr_i,
  output insn_t             fld_o,
  output logic              use_rb_o,
  output logic              legal_o
);
  assign fld_o    = insn_t'(instr_i);
  assign use_rb_o = (fld_o.opc == OPC_REG);
  assign legal_o  = use_rb_o | (fld_o.opc == OPC_IMM);
endmodule

// File: rtl/rotmask_rotator.sv
module rotmask_rotator #(
  parameter int unsigned W       = 32,
  parameter bit          LOG_ROT = 1'b1,
  localparam int unsigned SW     = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [SW-1:0] amt_i,
  output logic [W-1:0]  data_o
);
  if (LOG_ROT) begin : g_log
    logic [W-1:0] stg [SW+1];
    assign stg[0] = data_i;
    for (genvar k = 0; k < SW; k++) begin : g_stage
      localparam int unsigned R = 1 << k;
      assign stg[k+1] = amt_i[k] ? {stg[k][W-1-R:0], stg[k][W-1:W-R]} : stg[k];
    end
    assign data_o = stg[SW];
  end else begin : g_dbl
    logic [2*W-1:0] dbl;
    assign dbl    = {data_i, data_i} << amt_i;
    assign data_o = dbl[2*W-1:W];
  end
endmodule

// File: rtl/rotmask_mask_gen.sv
module rotmask_mask_gen #(
  parameter int unsigned W   = 32,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic [SW-1:0] mb_i,
  input  logic [SW-1:0] me_i,
  output logic [W-1:0]  mask_o
);
  logic wrap;
  assign wrap = (mb_i > me_i);

  // index i counts from the MSB
  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [SW-1:0] IDX = SW'(i);
    logic ge_b, le_e;
    assign ge_b = (IDX >= mb_i);
    assign le_e = (IDX <= me_i);
    assign mask_o[W-1-i] = wrap ? (ge_b | le_e) : (ge_b & le_e);
  end
endmodule

// File: rtl/rotmask_cond.sv
module rotmask_cond
  import rotmask_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] res_i,
  input  logic         so_i,
  output cr_t          cr_o
);
  always_comb begin
    cr_o.lt = res_i[W-1];
    cr_o.eq = ~|res_i;
    cr_o.gt = ~res_i[W-1] & (|res_i);
    cr_o.so = so_i;
  end
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
  import rotmask_pkg::*;
#(
  parameter int unsigned      XLEN    = 64,
  parameter int unsigned      WLEN    = 32,
  parameter logic [OPC_W-1:0] OPC_IMM = 6'd21,
  parameter logic [OPC_W-1:0] OPC_REG = 6'd23,
  parameter bit               LOG_ROT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [INSN_W-1:0] instr_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [XLEN-1:0]   rb_val_i,
  input  logic              so_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic              rd_we_o,
  output logic [XLEN-1:0]   result_o,
  output logic              cr_we_o,
  output logic [3:0]        cr0_o,
  output logic              illegal_o,
  output logic              xer_we_o
);
  localparam int unsigned SW = $clog2(WLEN);

  insn_t            fld;
  logic             use_rb, legal;
  logic [SW-1:0]    amt;
  logic [WLEN-1:0]  rot, mask, res_w;
  logic [XLEN-1:0]  res_x;
  cr_t              cr_d;

  rotmask_decode #(.OPC_IMM(OPC_IMM), .OPC_REG(OPC_REG)) u_dec (
    .instr_i (instr_i),
    .fld_o   (fld),
    .use_rb_o(use_rb),
    .legal_o (legal)
  );

  assign amt = use_rb ? rb_val_i[SW-1:0] : fld.amt_or_b[SW-1:0];

  rotmask_rotator #(.W(WLEN), .LOG_ROT(LOG_ROT)) u_rot (
    .data_i(rs_val_i[WLEN-1:0]),
    .amt_i (amt),
    .data_o(rot)
  );

  rotmask_mask_gen #(.W(WLEN)) u_mask (
    .mb_i  (fld.m_begin[SW-1:0]),
    .me_i  (fld.m_end[SW-1:0]),
    .mask_o(mask)
  );

  assign res_w = legal ? (rot & mask) : '0;
  assign res_x = {{(XLEN-WLEN){1'b0}}, res_w};

  rotmask_cond #(.W(WLEN)) u_cond (
    .res_i(res_w),
    .so_i (so_i),
    .cr_o (cr_d)
  );

  logic unused_ok;
  assign unused_ok = ^{rb_val_i[XLEN-1:SW], rs_val_i[XLEN-1:WLEN], fld.src_a};

  // output stage
  logic             vld_q, we_q, crwe_q, ill_q;
  logic [IDX_W-1:0] idx_q;
  logic [XLEN-1:0]  res_q;
  cr_t              cr_q;
  logic             take;

  assign in_ready_o = ~vld_q | out_ready_i;
  assign take       = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
    end else if (in_ready_o) begin
      vld_q <= in_valid_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b0;
      crwe_q <= 1'b0;
      ill_q  <= 1'b0;
      idx_q  <= '0;
      res_q  <= '0;
      cr_q   <= '0;
    end else if (take) begin
      we_q   <= legal;
      crwe_q <= legal & fld.rec;
      ill_q  <= ~legal;
      idx_q  <= fld.dst;
      res_q  <= res_x;
      cr_q   <= cr_d;
    end
  end

  assign out_valid_o = vld_q;
  assign rd_idx_o    = idx_q;
  assign rd_we_o     = vld_q & we_q;
  assign cr_we_o     = vld_q & crwe_q;
  assign illegal_o   = vld_q & ill_q;
  assign result_o    = res_q;
  assign cr0_o       = cr_q;
  assign xer_we_o    = 1'b0;
endmodule

// File: rtl/rotmask_chk.sv
module rotmask_chk #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned WLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic            in_ready_o,
  input logic            out_valid_o,
  input logic            out_ready_i,
  input logic [4:0]      rd_idx_o,
  input logic            rd_we_o,
  input logic [XLEN-1:0] result_o,
  input logic            cr_we_o,
  input logic [3:0]      cr0_o,
  input logic            illegal_o
);
  a_r6_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (result_o[XLEN-1:WLEN] == '0));

  a_r9_illegal_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && illegal_o) |-> (!rd_we_o && !cr_we_o && result_o == '0));

  a_r7_one_relation: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we_o |-> ($countones(cr0_o[3:1]) == 1));

  a_r7_eq_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we_o |-> (cr0_o[1] == (result_o[WLEN-1:0] == '0)));

  a_r7_lt_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_we_o |-> (cr0_o[3] == result_o[WLEN-1]));

  a_r10_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(result_o) && $stable(rd_idx_o) && $stable(cr0_o)));

  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (!rd_we_o && !cr_we_o && !illegal_o));
endmodule

bind rotmask_unit rotmask_chk #(.XLEN(XLEN), .WLEN(WLEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .rd_idx_o   (rd_idx_o),
  .rd_we_o    (rd_we_o),
  .result_o   (result_o),
  .cr_we_o    (cr_we_o),
  .cr0_o      (cr0_o),
  .illegal_o  (illegal_o)
);

// File: tb/sim_rotmask_unit.sv
`timescale 1ns/1ps
module sim_rotmask_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] instr = '0;
  logic [63:0] rs_val = '0;
  logic [63:0] rb_val = '0;
  logic        so = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [4:0]  rd_idx;
  logic        rd_we;
  logic [63:0] result;
  logic        cr_we;
  logic [3:0]  cr0;
  logic        illegal;
  logic        xer_we;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  rotmask_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .instr_i(instr), .rs_val_i(rs_val), .rb_val_i(rb_val), .so_i(so),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .rd_idx_o(rd_idx),
    .rd_we_o(rd_we), .result_o(result), .cr_we_o(cr_we), .cr0_o(cr0),
    .illegal_o(illegal), .xer_we_o(xer_we)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int opc, input int ra, input int sh,
                                     input int mb, input int me, input bit rc);
    return {6'(opc), 5'd3, 5'(ra), 5'(sh), 5'(mb), 5'(me), rc};
  endfunction

  function automatic logic [31:0] ref_mask(input int mb, input int me);
    logic [31:0] lo, hi;
    logic [63:0] t;
    lo = 32'hFFFF_FFFF >> mb;
    t  = 64'hFFFF_FFFF >> (me + 1);
    hi = ~t[31:0];
    return (mb <= me) ? (lo & hi) : (lo | hi);
  endfunction

  // expected output for one operation, checked at the current sample point
  task automatic expect_op(input logic [31:0] ins, input logic [63:0] rs, input logic [63:0] rb,
                           input bit s, input string tag);
    int opc, amt, mb, me;
    bit legal, rc;
    logic [63:0] x, r64;
    logic [31:0] res;
    logic [3:0] ecr;
    opc   = int'(ins[31:26]);
    legal = (opc == 21) || (opc == 23);
    amt   = (opc == 23) ? int'(rb[4:0]) : int'(ins[15:11]);
    mb    = int'(ins[10:6]);
    me    = int'(ins[5:1]);
    rc    = ins[0];
    x     = {32'd0, rs[31:0]};
    r64   = (x << amt) | (x >> (32 - amt));
    res   = legal ? (r64[31:0] & ref_mask(mb, me)) : 32'd0;
    ecr   = {res[31], (!res[31] && res != 0), (res == 0), s};
    chk(out_valid === 1'b1, {tag, " R10 valid"}, 64'(out_valid), 64'd1);
    chk(result === {32'd0, res}, {tag, " R6 result"}, result, {32'd0, res});
    chk(rd_we === legal, {tag, " R9 rd_we"}, 64'(rd_we), 64'(legal));
    chk(illegal === !legal, {tag, " R9 illegal"}, 64'(illegal), 64'(!legal));
    chk(cr_we === (legal && rc), {tag, " R7 cr_we"}, 64'(cr_we), 64'(legal && rc));
    if (legal) chk(rd_idx === ins[20:16], {tag, " R1 rd_idx"}, 64'(rd_idx), 64'(ins[20:16]));
    if (legal && rc) chk(cr0 === ecr, {tag, " R7 cr0"}, 64'(cr0), 64'(ecr));
    chk(xer_we === 1'b0, {tag, " R8 xer_we"}, 64'(xer_we), 64'd0);
  endtask

  task automatic run_op(input logic [31:0] ins, input logic [63:0] rs, input logic [63:0] rb,
                        input bit s, input string tag);
    @(negedge clk);
    instr = ins; rs_val = rs; rb_val = rb; so = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    expect_op(ins, rs, rb, s, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] ia, ib, ic;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(out_valid === 1'b0 && rd_we === 1'b0 && cr_we === 1'b0 && illegal === 1'b0,
        "R11 reset outputs", {out_valid, rd_we, cr_we, illegal}, 64'd0);
    chk(in_ready === 1'b1, "R11 reset ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;

    // R5: every begin/end pair, including wrap, all-ones and single-bit masks
    for (int mb = 0; mb < 32; mb++)
      for (int me = 0; me < 32; me++)
        run_op(mk(21, (mb + me) % 32, (mb * 3 + me) % 32, mb, me, bit'((mb ^ me) & 1)),
               {32'hDEAD_BEEF, 32'hA5C3_0F96 ^ 32'(mb * 32'h0101_0101)},
               {59'h5A5_A5A5_A5A5_A5A5, 5'(~(mb + me))}, bit'(mb & 1), "R5 sweep");

    // R5 degenerate masks, checked directly
    run_op(mk(21, 1, 0, 5, 4, 1'b0), 64'hFFFF_FFFF, 64'd0, 1'b0, "R5 all ones");
    chk(result === 64'h0000_0000_FFFF_FFFF, "R5 all ones value", result, 64'hFFFF_FFFF);
    run_op(mk(21, 1, 0, 7, 7, 1'b0), 64'hFFFF_FFFF, 64'd0, 1'b0, "R5 one bit");
    chk(result === 64'h0000_0000_0100_0000, "R5 one bit value", result, 64'h0100_0000);

    // R2: register amount, upper RB bits and immediate field are decoys
    for (int a = 0; a < 32; a++)
      run_op(mk(23, a, (a + 13) % 32, 0, 31, 1'b1), {32'hFFFF_0000, 32'h8000_0013},
             {59'h7FF_FFFF_FFFF_FFFF ^ 59'(a), 5'(a)}, 1'b1, "R2 reg amount");

    // R3 and R4: immediate amount, RB decoy, upper RS ignored
    for (int a = 0; a < 32; a++)
      run_op(mk(21, 31 - a, a, 0, 31, 1'b0), {32'h1234_5678, 32'hC000_0005},
             {64'hFFFF_FFFF_FFFF_FFE0 | 64'(~a & 31)}, 1'b0, "R3 imm amount");
    run_op(mk(21, 2, 4, 0, 31, 1'b0), 64'hFFFF_FFFF_1000_0001, 64'd0, 1'b0, "R4 rotate");
    chk(result === 64'h0000_0000_0000_0011, "R4 wrap bits", result, 64'h11);

    // R7: signed compare outcomes and SO copy; record clear
    run_op(mk(21, 4, 0, 0, 0, 1'b1), 64'h8000_0000, 64'd0, 1'b1, "R7 negative");
    chk(cr0 === 4'b1001, "R7 lt so", 64'(cr0), 64'h9);
    run_op(mk(21, 4, 0, 0, 31, 1'b1), 64'h0, 64'd0, 1'b0, "R7 zero");
    chk(cr0 === 4'b0010, "R7 eq", 64'(cr0), 64'h2);
    run_op(mk(21, 4, 0, 31, 31, 1'b1), 64'h1, 64'd0, 1'b1, "R7 positive");
    chk(cr0 === 4'b0101, "R7 gt so", 64'(cr0), 64'h5);
    run_op(mk(23, 4, 0, 0, 31, 1'b0), 64'h1, 64'd0, 1'b1, "R7 no record");

    // R9: all other opcodes
    for (int o = 0; o < 64; o++)
      if (o != 21 && o != 23)
        run_op(mk(o, 9, 5, 0, 31, 1'b1), 64'hFFFF_FFFF, 64'd1, 1'b0, "R9 bad opcode");

    // R1: every destination index
    for (int r = 0; r < 32; r++)
      run_op(mk(23, r, 0, 16, 15, 1'b0), 64'(r), 64'd0, 1'b0, "R1 dest");

    // R10: back-to-back stream
    ia = mk(21, 1, 4, 0, 31, 1'b1);
    ib = mk(23, 2, 0, 8, 3, 1'b1);
    ic = mk(21, 3, 31, 20, 20, 1'b0);
    @(negedge clk);
    instr = ia; rs_val = 64'h0F0F_1234; rb_val = 64'd0; so = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    expect_op(ia, 64'h0F0F_1234, 64'd0, 1'b0, "R10 stream a");
    instr = ib; rs_val = 64'h8765_4321; rb_val = 64'd7; so = 1'b1;
    @(negedge clk);
    expect_op(ib, 64'h8765_4321, 64'd7, 1'b1, "R10 stream b");
    instr = ic; rs_val = 64'hFFFF_FFFF; rb_val = 64'd0; so = 1'b0;
    @(negedge clk);
    expect_op(ic, 64'hFFFF_FFFF, 64'd0, 1'b0, "R10 stream c");
    in_valid = 1'b0;

    // R10: stall holds the beat and blocks the next input
    @(negedge clk);
    out_ready = 1'b0;
    instr = ia; rs_val = 64'h0F0F_1234; rb_val = 64'd0; so = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    expect_op(ia, 64'h0F0F_1234, 64'd0, 1'b0, "R10 stall first");
    chk(in_ready === 1'b0, "R10 not ready", 64'(in_ready), 64'd0);
    instr = ib; rs_val = 64'h8765_4321; rb_val = 64'd7; so = 1'b1;
    @(negedge clk);
    expect_op(ia, 64'h0F0F_1234, 64'd0, 1'b0, "R10 stall held");
    out_ready = 1'b1;
    @(negedge clk);
    expect_op(ib, 64'h8765_4321, 64'd7, 1'b1, "R10 after stall");
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R10 drained", 64'(out_valid), 64'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule